// File: doc/BRIEF.md
# DMA Global Control and Interrupt Front End

This block is the register front end for a DMA controller with up to 32 channel engines. A host reaches it through a 32-bit request/response register bus with valid/ready handshakes on both sides. The upper half of the address space holds a few global registers, described in R2 through R8. These include a controller enable, a stored performance-mode option, two sticky error summaries fed by the channels, and a per-channel interrupt pending vector that drives a single interrupt line. They also include a doorbell that asks individual channels to fetch a descriptor, and a free 32-bit channel-programmable mask.

The lower half of the address space is divided into one eight-word window per channel. An access that falls into a window is forwarded to that channel engine. The engine sees a one-hot request valid and shared payload signals. It answers with its own response valid and data. The front end then returns that answer to the host.

The host bus carries one transaction at a time. `req_ready` is high only while the block is idle. The block holds a response on `rsp_valid`/`rsp_rdata` unchanged until the host raises `rsp_ready`. Every request gets exactly one response, and write responses carry zero data. On the channel side, the block holds its request until that channel's ready bit is high. After that handshake, it waits for a response pulse from the same channel. A response that arrives in the handshake cycle itself is not captured.

Top module: `dma_gctl`

## Requirements
- R1: After reset, every global register reads 0. `irq`, `fetch_req`, `ctrl_enable`, `ctrl_perf`, `chan_prog` and `rsp_valid` are 0, and `req_ready` is 1.
- R2: The control word sits at byte address 0x1000. Bit 0 is the controller enable, which drives `ctrl_enable`. Bit 31 is a stored option, which drives `ctrl_perf`. Both bits are written directly and read back at those positions. Bits 1 and 4 to 30 read 0.
- R3: Control bit 2 is set when any `ch_addr_err` bit is high, and control bit 3 is set when any `ch_halt` bit is high. A control write that carries 0 in one of these bits clears it. A control write that carries 1 leaves it unchanged.
- R4: A high `ch_irq[n]` sets bit n of the pending word at 0x1004. A write to 0x1004 clears every pending bit written as 0, so writing 0 clears all of them.
- R5: When a channel event and a software clear of the same bit land in the same cycle, the bit ends up set. This applies to pending bits, both error flags and doorbell bits.
- R6: `irq` is high exactly when the enable bit is 1 and at least one pending bit is 1.
- R7: Writing 1 to bit n of the doorbell-set address 0x100C raises `fetch_req[n]`. The bit stays high until `fetch_ack[n]` is seen or software clears it. A write to the doorbell word at 0x1008 clears bits written as 0. Address 0x1008 reads the current `fetch_req` vector, and address 0x100C reads 0.
- R8: The word at 0x101C is a plain read/write register driving `chan_prog`.
- R9: A byte address A below 0x1000, with A/32 less than the channel count, targets channel A/32 and register (A/4) mod 8. Only that channel's `ch_req_valid` bit rises. It stays high until the same channel's `ch_req_ready` bit is high. The response data from that channel is returned to the host.
- R10: A read of any other address returns 0, and a write to it changes no state and issues no channel request.
- R11: `req_ready` is high only when no transaction is in flight. A response stays valid with stable data until `rsp_ready`, and a global-register response appears in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Host request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| ch_req_valid | output | 32 | One-hot request to a channel engine |
| ch_req_ready | input | 32 | Per-channel request acceptance |
| ch_req_reg | output | 3 | Register index inside the channel window |
| ch_req_write | output | 1 | Channel access is a write |
| ch_req_wdata | output | 32 | Channel write data |
| ch_rsp_valid | input | 32 | Per-channel response pulse |
| ch_rsp_rdata | input | 1024 | Per-channel response data, channel n at bits 32n+31:32n |
| ch_irq | input | 32 | Per-channel interrupt events |
| ch_addr_err | input | 32 | Per-channel address-error events |
| ch_halt | input | 32 | Per-channel halt events |
| fetch_ack | input | 32 | Channel has taken its doorbell |
| fetch_req | output | 32 | Outstanding doorbells per channel |
| ctrl_enable | output | 1 | Controller enable |
| ctrl_perf | output | 1 | Stored performance option |
| chan_prog | output | 32 | Channel-programmable mask |
| irq | output | 1 | Aggregated interrupt |

## Verification
Channel events and software clear writes can fall in the same cycle. This applies to a pending bit, an error flag, or a doorbell bit with its acknowledge. The bench provokes each case by pulsing the event in exactly the cycle in which the bus accepts the clearing write, which is possible because an idle block accepts on the first edge. The outcome is judged by reading the register back and checking that the bit survived. It is also checked every clock against a behavioural model that applies the event after the clear.

// File: rtl/dma_gctl_pkg.sv
package dma_gctl_pkg;
  typedef enum logic [2:0] {
    GS_NONE,
    GS_CTRL,
    GS_PEND,
    GS_DBELL,
    GS_DBSET,
    GS_PROG
  } gsel_e;

  typedef enum logic [1:0] {
    BS_IDLE,
    BS_CREQ,
    BS_CWAIT,
    BS_RSP
  } bstate_e;

  // word index inside the global region (byte offset / 4)
  localparam int GW_CTRL  = 0;
  localparam int GW_PEND  = 1;
  localparam int GW_DBELL = 2;
  localparam int GW_DBSET = 3;
  localparam int GW_PROG  = 7;

  // control word bit positions (the option bit is the top data bit)
  localparam int CB_EN   = 0;
  localparam int CB_AERR = 2;
  localparam int CB_HALT = 3;
endpackage

// File: rtl/dma_gctl_stick.sv
module dma_gctl_stick #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  // set takes priority over clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr) | set;
  end
endmodule

// File: rtl/dma_gctl_decode.sv
module dma_gctl_decode
  import dma_gctl_pkg::*;
#(
  parameter  int ADDR_W  = 13,
  parameter  int NUM_CH  = 32,
  parameter  int CH_REGS = 8,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int REG_W   = $clog2(CH_REGS)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              is_chan,
  output logic [CH_W-1:0]   ch_idx,
  output logic [REG_W-1:0]  ch_reg,
  output gsel_e             gsel
);
  localparam int WIN_SHIFT = REG_W + 2;
  localparam int HI_W      = ADDR_W - 1 - WIN_SHIFT;

  logic [HI_W-1:0]   win_no;
  logic [ADDR_W-4:0] gword;
  logic              unused_lsb;

  assign win_no     = addr[ADDR_W-2:WIN_SHIFT];
  assign gword      = addr[ADDR_W-2:2];
  assign unused_lsb = ^addr[1:0];

  assign is_chan = !addr[ADDR_W-1] && ({1'b0, win_no} < (HI_W+1)'(NUM_CH));
  assign ch_idx  = addr[WIN_SHIFT +: CH_W];
  assign ch_reg  = addr[2 +: REG_W];

  always_comb begin
    gsel = GS_NONE;
    if (addr[ADDR_W-1]) begin
      case (int'(gword))
        GW_CTRL:  gsel = GS_CTRL;
        GW_PEND:  gsel = GS_PEND;
        GW_DBELL: gsel = GS_DBELL;
        GW_DBSET: gsel = GS_DBSET;
        GW_PROG:  gsel = GS_PROG;
        default:  gsel = GS_NONE;
      endcase
    end
  end
endmodule

// File: rtl/dma_gctl_regs.sv
module dma_gctl_regs
  import dma_gctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  gsel_e             wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  gsel_e             rd_sel,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NUM_CH-1:0] ch_irq,
  input  logic [NUM_CH-1:0] ch_addr_err,
  input  logic [NUM_CH-1:0] ch_halt,
  input  logic [NUM_CH-1:0] fetch_ack,
  output logic [NUM_CH-1:0] fetch_req,
  output logic              ctrl_enable,
  output logic              ctrl_perf,
  output logic [DATA_W-1:0] chan_prog,
  output logic              irq
);
  logic wr_ctrl, wr_pend, wr_dbell, wr_dbset, wr_prog;
  logic [NUM_CH-1:0] pend_q, db_q;
  logic [NUM_CH-1:0] wmask;
  logic [1:0]        flag_q;   // [0] address error, [1] halt
  logic              en_q, perf_q;
  logic [DATA_W-1:0] prog_q;

  assign wr_ctrl  = wr_en && (wr_sel == GS_CTRL);
  assign wr_pend  = wr_en && (wr_sel == GS_PEND);
  assign wr_dbell = wr_en && (wr_sel == GS_DBELL);
  assign wr_dbset = wr_en && (wr_sel == GS_DBSET);
  assign wr_prog  = wr_en && (wr_sel == GS_PROG);
  assign wmask    = wr_data[NUM_CH-1:0];

  dma_gctl_stick #(.W(NUM_CH)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .set(ch_irq),
    .clr({NUM_CH{wr_pend}} & ~wmask),
    .q(pend_q)
  );

  dma_gctl_stick #(.W(NUM_CH)) u_dbell (
    .clk(clk), .rst_n(rst_n),
    .set({NUM_CH{wr_dbset}} & wmask),
    .clr(({NUM_CH{wr_dbell}} & ~wmask) | fetch_ack),
    .q(db_q)
  );

  dma_gctl_stick #(.W(2)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .set({|ch_halt, |ch_addr_err}),
    .clr({2{wr_ctrl}} & ~{wr_data[CB_HALT], wr_data[CB_AERR]}),
    .q(flag_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      perf_q <= 1'b0;
      prog_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= wr_data[CB_EN];
        perf_q <= wr_data[DATA_W-1];
      end
      if (wr_prog) prog_q <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      GS_CTRL: begin
        rd_data[CB_EN]      = en_q;
        rd_data[CB_AERR]    = flag_q[0];
        rd_data[CB_HALT]    = flag_q[1];
        rd_data[DATA_W-1]   = perf_q;
      end
      GS_PEND:  rd_data = DATA_W'(pend_q);
      GS_DBELL: rd_data = DATA_W'(db_q);
      GS_PROG:  rd_data = prog_q;
      default:  rd_data = '0;
    endcase
  end

  assign fetch_req   = db_q;
  assign ctrl_enable = en_q;
  assign ctrl_perf   = perf_q;
  assign chan_prog   = prog_q;
  assign irq         = en_q && (|pend_q);

  // R4: every interrupt event is visible in the pending word one cycle later
  a_r4_pend_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_irq) |=> ((pend_q & $past(ch_irq)) == $past(ch_irq)));

  // R3 / R5: a halt event always leaves the halt summary set
  a_r3_halt_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_halt) |=> flag_q[1]);

  // R7: a doorbell bit only rises after a doorbell-set write
  a_r7_no_spurious_ring: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (wr_sel == GS_DBSET)) |=> ((db_q & ~$past(db_q)) == '0));
endmodule

// File: rtl/dma_gctl_bus.sv
module dma_gctl_bus
  import dma_gctl_pkg::*;
#(
  parameter  int ADDR_W  = 13,
  parameter  int DATA_W  = 32,
  parameter  int NUM_CH  = 32,
  parameter  int CH_REGS = 8,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int REG_W   = $clog2(CH_REGS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic [NUM_CH-1:0]        ch_req_valid,
  input  logic [NUM_CH-1:0]        ch_req_ready,
  output logic [REG_W-1:0]         ch_req_reg,
  output logic                     ch_req_write,
  output logic [DATA_W-1:0]        ch_req_wdata,
  input  logic [NUM_CH-1:0]        ch_rsp_valid,
  input  logic [NUM_CH*DATA_W-1:0] ch_rsp_rdata,
  output logic                     g_wr_en,
  output gsel_e                    g_sel,
  input  logic [DATA_W-1:0]        g_rdata
);
  bstate_e           state_q;
  logic [CH_W-1:0]   sel_q;
  logic [REG_W-1:0]  reg_q;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  logic              dec_chan;
  logic [CH_W-1:0]   dec_idx;
  logic [REG_W-1:0]  dec_reg;
  logic              accept;

  dma_gctl_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .CH_REGS(CH_REGS)) u_dec (
    .addr(req_addr), .is_chan(dec_chan), .ch_idx(dec_idx),
    .ch_reg(dec_reg), .gsel(g_sel)
  );

  assign req_ready = (state_q == BS_IDLE);
  assign accept    = req_valid && req_ready;
  assign g_wr_en   = accept && req_write && !dec_chan && (g_sel != GS_NONE);

  // per-channel routing
  logic [DATA_W-1:0] ch_rd_arr [NUM_CH];
  for (genvar i = 0; i < NUM_CH; i++) begin : g_route
    assign ch_rd_arr[i]    = ch_rsp_rdata[i*DATA_W +: DATA_W];
    assign ch_req_valid[i] = (state_q == BS_CREQ) && (sel_q == CH_W'(i));
  end

  logic              sel_ready, sel_rvalid;
  logic [DATA_W-1:0] sel_rdata;
  assign sel_ready  = ch_req_ready[sel_q];
  assign sel_rvalid = ch_rsp_valid[sel_q];
  assign sel_rdata  = ch_rd_arr[sel_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BS_IDLE;
      sel_q   <= '0;
      reg_q   <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      case (state_q)
        BS_IDLE: if (req_valid) begin
          if (dec_chan) begin
            sel_q   <= dec_idx;
            reg_q   <= dec_reg;
            wr_q    <= req_write;
            wdata_q <= req_wdata;
            state_q <= BS_CREQ;
          end else begin
            rdata_q <= req_write ? '0 : g_rdata;
            state_q <= BS_RSP;
          end
        end
        BS_CREQ:  if (sel_ready) state_q <= BS_CWAIT;
        BS_CWAIT: if (sel_rvalid) begin
          rdata_q <= wr_q ? '0 : sel_rdata;
          state_q <= BS_RSP;
        end
        BS_RSP:   if (rsp_ready) state_q <= BS_IDLE;
        default:  state_q <= BS_IDLE;
      endcase
    end
  end

  assign rsp_valid    = (state_q == BS_RSP);
  assign rsp_rdata    = rdata_q;
  assign ch_req_reg   = reg_q;
  assign ch_req_write = wr_q;
  assign ch_req_wdata = wdata_q;

  // R11: a response waits, unchanged, for the host
  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R11: nothing more is accepted while a transaction is in flight
  a_r11_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // R9: a channel request holds until its own ready
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ch_req_valid & ~ch_req_ready)) |=> ((|ch_req_valid) && $stable(ch_req_valid)));
endmodule

// File: rtl/dma_gctl.sv
module dma_gctl
  import dma_gctl_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int DATA_W  = 32,
  parameter int NUM_CH  = 32,
  parameter int CH_REGS = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_write,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [DATA_W-1:0]          req_wdata,
  output logic                       rsp_valid,
  input  logic                       rsp_ready,
  output logic [DATA_W-1:0]          rsp_rdata,
  output logic [NUM_CH-1:0]          ch_req_valid,
  input  logic [NUM_CH-1:0]          ch_req_ready,
  output logic [$clog2(CH_REGS)-1:0] ch_req_reg,
  output logic                       ch_req_write,
  output logic [DATA_W-1:0]          ch_req_wdata,
  input  logic [NUM_CH-1:0]          ch_rsp_valid,
  input  logic [NUM_CH*DATA_W-1:0]   ch_rsp_rdata,
  input  logic [NUM_CH-1:0]          ch_irq,
  input  logic [NUM_CH-1:0]          ch_addr_err,
  input  logic [NUM_CH-1:0]          ch_halt,
  input  logic [NUM_CH-1:0]          fetch_ack,
  output logic [NUM_CH-1:0]          fetch_req,
  output logic                       ctrl_enable,
  output logic                       ctrl_perf,
  output logic [DATA_W-1:0]          chan_prog,
  output logic                       irq
);
  logic              g_wr_en;
  gsel_e             g_sel;
  logic [DATA_W-1:0] g_rdata;

  dma_gctl_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CH(NUM_CH), .CH_REGS(CH_REGS)) u_bus (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .ch_req_valid(ch_req_valid), .ch_req_ready(ch_req_ready),
    .ch_req_reg(ch_req_reg), .ch_req_write(ch_req_write), .ch_req_wdata(ch_req_wdata),
    .ch_rsp_valid(ch_rsp_valid), .ch_rsp_rdata(ch_rsp_rdata),
    .g_wr_en(g_wr_en), .g_sel(g_sel), .g_rdata(g_rdata)
  );

  dma_gctl_regs #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(g_wr_en), .wr_sel(g_sel), .wr_data(req_wdata),
    .rd_sel(g_sel), .rd_data(g_rdata),
    .ch_irq(ch_irq), .ch_addr_err(ch_addr_err), .ch_halt(ch_halt),
    .fetch_ack(fetch_ack), .fetch_req(fetch_req),
    .ctrl_enable(ctrl_enable), .ctrl_perf(ctrl_perf),
    .chan_prog(chan_prog), .irq(irq)
  );
endmodule

// File: tb/dma_gctl_tb.sv
module dma_gctl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic        req_valid = 0, req_write = 0, rsp_ready = 0;
  logic [12:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic [31:0] ch_req_valid;
  logic [31:0] ch_req_ready = '0;
  logic [2:0]  ch_req_reg;
  logic        ch_req_write;
  logic [31:0] ch_req_wdata;
  logic [31:0] ch_rsp_valid = '0;
  logic [1023:0] ch_rsp_rdata = '0;
  logic [31:0] ch_irq = '0, ch_addr_err = '0, ch_halt = '0, fetch_ack = '0;
  logic [31:0] fetch_req, chan_prog;
  logic        ctrl_enable, ctrl_perf, irq;

  dma_gctl u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .ch_req_valid(ch_req_valid), .ch_req_ready(ch_req_ready),
    .ch_req_reg(ch_req_reg), .ch_req_write(ch_req_write), .ch_req_wdata(ch_req_wdata),
    .ch_rsp_valid(ch_rsp_valid), .ch_rsp_rdata(ch_rsp_rdata),
    .ch_irq(ch_irq), .ch_addr_err(ch_addr_err), .ch_halt(ch_halt),
    .fetch_ack(fetch_ack), .fetch_req(fetch_req),
    .ctrl_enable(ctrl_enable), .ctrl_perf(ctrl_perf),
    .chan_prog(chan_prog), .irq(irq)
  );

  int total = 0, bad = 0;
  bit run_cmp = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic        m_en, m_perf, m_aerr, m_halt;
  logic [31:0] m_pend, m_db, m_prog;
  int          chmem [256];
  wire m_wr = req_valid && req_ready && req_write;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en <= 0; m_perf <= 0; m_aerr <= 0; m_halt <= 0;
      m_pend <= 0; m_db <= 0; m_prog <= 0;
    end else begin
      m_pend <= ((m_wr && req_addr == 13'h1004) ? (m_pend & req_wdata) : m_pend) | ch_irq;
      m_aerr <= ((m_wr && req_addr == 13'h1000) ? (m_aerr & req_wdata[2]) : m_aerr) | (|ch_addr_err);
      m_halt <= ((m_wr && req_addr == 13'h1000) ? (m_halt & req_wdata[3]) : m_halt) | (|ch_halt);
      if (m_wr && req_addr == 13'h1000) begin
        m_en   <= req_wdata[0];
        m_perf <= req_wdata[31];
      end
      m_db <= ((((m_wr && req_addr == 13'h1008) ? (m_db & req_wdata) : m_db)) & ~fetch_ack)
              | ((m_wr && req_addr == 13'h100C) ? req_wdata : 32'h0);
      if (m_wr && req_addr == 13'h101C) m_prog <= req_wdata;
    end
  end

  function automatic logic [31:0] mread(input logic [12:0] a);
    case (a)
      13'h1000: return {m_perf, 27'h0, m_halt, m_aerr, 1'b0, m_en};
      13'h1004: return m_pend;
      13'h1008: return m_db;
      13'h100C: return 32'h0;
      13'h101C: return m_prog;
      default:  return (a < 13'h0400) ? chmem[(int'(a) >> 5) * 8 + ((int'(a) >> 2) & 7)] : 32'h0;
    endcase
  endfunction

  // per-clock comparison of the observable outputs
  always @(negedge clk) begin
    if (run_cmp) begin
      chk("R6 irq", {31'h0, irq}, {31'h0, m_en && (m_pend != 0)});
      chk("R7 fetch_req", fetch_req, m_db);
      chk("R2 ctrl_enable", {31'h0, ctrl_enable}, {31'h0, m_en});
      chk("R2 ctrl_perf", {31'h0, ctrl_perf}, {31'h0, m_perf});
      chk("R8 chan_prog", chan_prog, m_prog);
    end
  end

  // ---------------- channel engine responder ----------------
  int req_cnt = 0, last_idx = -1, last_reg = -1;
  initial begin
    for (int i = 0; i < 256; i++) chmem[i] = 0;
    forever begin
      @(negedge clk);
      if (rst_n && (ch_req_valid != 0)) begin
        int idx;
        int rg;
        logic [31:0] d;
        logic wr;
        logic [31:0] wd;
        idx = 0;
        chk("R9 onehot valid", $countones(ch_req_valid), 1);
        for (int i = 0; i < 32; i++) if (ch_req_valid[i]) idx = i;
        rg = int'(ch_req_reg);
        wr = ch_req_write;
        wd = ch_req_wdata;
        @(negedge clk);
        chk("R9 request held", ch_req_valid, 32'h1 << idx);
        ch_req_ready[idx] = 1'b1;
        @(negedge clk);
        ch_req_ready = '0;
        if (wr) chmem[idx*8 + rg] = int'(wd);
        d = wr ? 32'hDEAD_0000 : chmem[idx*8 + rg];
        @(negedge clk);
        ch_rsp_rdata[idx*32 +: 32] = d;
        ch_rsp_valid[idx] = 1'b1;
        @(negedge clk);
        ch_rsp_valid = '0;
        req_cnt++;
        last_idx = idx;
        last_reg = rg;
      end
    end
  end

  // ---------------- host access task ----------------
  task automatic bus(input bit wr, input logic [12:0] a, input logic [31:0] wd,
                     input logic [31:0] e_irq, input logic [31:0] e_halt,
                     input logic [31:0] e_aerr, input logic [31:0] e_ack,
                     input int hold, output logic [31:0] rd, output logic [31:0] ex);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd;
    ch_irq = e_irq; ch_halt = e_halt; ch_addr_err = e_aerr; fetch_ack = e_ack;
    forever begin
      @(posedge clk);
      if (req_ready) break;
    end
    ex = wr ? 32'h0 : mread(a);
    @(negedge clk);
    req_valid = 0;
    ch_irq = '0; ch_halt = '0; ch_addr_err = '0; fetch_ack = '0;
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk("R11 response held", {rsp_valid, rsp_rdata[30:0]}, {1'b1, rd[30:0]});
    end
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
  endtask

  task automatic rw(input string tag, input bit wr, input logic [12:0] a, input logic [31:0] wd);
    logic [31:0] rd, ex;
    bus(wr, a, wd, 0, 0, 0, 0, 0, rd, ex);
    chk(tag, rd, ex);
  endtask

  task automatic rd_exp(input string tag, input logic [12:0] a, input logic [31:0] exp);
    logic [31:0] rd, ex;
    bus(0, a, 0, 0, 0, 0, 0, 0, rd, ex);
    chk(tag, rd, exp);
  endtask

  task automatic pulse(input logic [31:0] e_irq, input logic [31:0] e_halt,
                       input logic [31:0] e_aerr, input logic [31:0] e_ack);
    @(negedge clk);
    ch_irq = e_irq; ch_halt = e_halt; ch_addr_err = e_aerr; fetch_ack = e_ack;
    @(negedge clk);
    ch_irq = '0; ch_halt = '0; ch_addr_err = '0; fetch_ack = '0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL R11 watchdog act=hung exp=completed");
    finish_run();
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [31:0] rd, ex;
    int cnt0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 req_ready after reset", {31'h0, req_ready}, 32'h1);
    chk("R1 rsp_valid after reset", {31'h0, rsp_valid}, 32'h0);
    chk("R1 irq after reset", {31'h0, irq}, 32'h0);
    chk("R1 fetch_req after reset", fetch_req, 32'h0);
    run_cmp = 1;
    rd_exp("R1 ctrl reset", 13'h1000, 32'h0);
    rd_exp("R1 pend reset", 13'h1004, 32'h0);
    rd_exp("R1 dbell reset", 13'h1008, 32'h0);
    rd_exp("R1 prog reset", 13'h101C, 32'h0);

    // R2 control fields and R11 response timing
    rw("R2 ctrl write", 1, 13'h1000, 32'h8000_0001);
    rd_exp("R2 ctrl readback", 13'h1000, 32'h8000_0001);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 13'h1000;
    @(negedge clk);
    req_valid = 0;
    chk("R11 global response next cycle", {rsp_valid, rsp_rdata[30:0]}, {1'b1, 31'h1});
    chk("R11 busy while responding", {31'h0, req_ready}, 32'h0);
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    rw("R2 ctrl write ones", 1, 13'h1000, 32'hFFFF_FFFF);
    rd_exp("R3 writing 1 does not set flags", 13'h1000, 32'h8000_0001);

    // R3 error summaries
    pulse(0, 32'h0000_0020, 0, 0);
    rd_exp("R3 halt flag set", 13'h1000, 32'h8000_0009);
    pulse(0, 0, 32'h8000_0000, 0);
    rd_exp("R3 addr err flag set", 13'h1000, 32'h8000_000D);
    rw("R3 clear flags", 1, 13'h1000, 32'h8000_0001);
    rd_exp("R3 flags cleared", 13'h1000, 32'h8000_0001);

    // R4 / R6 pending and interrupt line
    pulse(32'h0002_0001, 0, 0, 0);
    rd_exp("R4 pending bits", 13'h1004, 32'h0002_0001);
    @(negedge clk);
    chk("R6 irq with enable", {31'h0, irq}, 32'h1);
    rw("R6 disable", 1, 13'h1000, 32'h0);
    @(negedge clk);
    chk("R6 irq gated by enable", {31'h0, irq}, 32'h0);
    rw("R6 enable", 1, 13'h1000, 32'h1);
    rw("R4 partial clear", 1, 13'h1004, 32'hFFFF_FFFE);
    rd_exp("R4 partial clear result", 13'h1004, 32'h0002_0000);
    rw("R4 clear all", 1, 13'h1004, 32'h0);
    rd_exp("R4 all cleared", 13'h1004, 32'h0);
    @(negedge clk);
    chk("R6 irq low with nothing pending", {31'h0, irq}, 32'h0);

    // R5 collisions: event in the accept cycle of a clearing write
    bus(1, 13'h1004, 32'h0, 32'h0000_0200, 0, 0, 0, 0, rd, ex);
    rd_exp("R5 pending set wins over clear", 13'h1004, 32'h0000_0200);
    bus(1, 13'h1000, 32'h0000_0001, 0, 32'h1, 32'h4, 0, 0, rd, ex);
    rd_exp("R5 flags set win over clear", 13'h1000, 32'h0000_000D);
    rw("R5 cleanup flags", 1, 13'h1000, 32'h1);
    rw("R5 cleanup pending", 1, 13'h1004, 32'h0);

    // R7 doorbell
    rw("R7 ring", 1, 13'h100C, 32'h0000_0104);
    @(negedge clk);
    chk("R7 fetch_req raised", fetch_req, 32'h0000_0104);
    rd_exp("R7 doorbell readback", 13'h1008, 32'h0000_0104);
    rd_exp("R7 set address reads zero", 13'h100C, 32'h0);
    pulse(0, 0, 0, 32'h0000_0004);
    @(negedge clk);
    chk("R7 ack drops bit", fetch_req, 32'h0000_0100);
    rw("R7 software clear", 1, 13'h1008, 32'h0);
    @(negedge clk);
    chk("R7 cleared by write", fetch_req, 32'h0);
    bus(1, 13'h100C, 32'h0000_0010, 0, 0, 0, 32'h0000_0010, 0, rd, ex);
    @(negedge clk);
    chk("R5 ring wins over ack", fetch_req, 32'h0000_0010);
    pulse(0, 0, 0, 32'h0000_0010);

    // R8 channel-programmable word
    rw("R8 prog write", 1, 13'h101C, 32'hA5A5_5A5A);
    rd_exp("R8 prog readback", 13'h101C, 32'hA5A5_5A5A);

    // R9 channel windows
    rw("R9 ch3 write", 1, 13'h0068, 32'h1111_3333);
    chk("R9 ch3 index", last_idx, 3);
    chk("R9 ch3 register", last_reg, 2);
    rw("R9 ch4 write", 1, 13'h0088, 32'h2222_4444);
    rd_exp("R9 ch3 read routed", 13'h0068, 32'h1111_3333);
    rd_exp("R9 ch4 read routed", 13'h0088, 32'h2222_4444);
    rw("R9 ch31 last reg write", 1, 13'h03FC, 32'h7777_0031);
    chk("R9 ch31 index", last_idx, 31);
    chk("R9 ch31 register", last_reg, 7);
    rd_exp("R9 ch31 readback", 13'h03FC, 32'h7777_0031);

    // R10 unmapped
    cnt0 = req_cnt;
    rd_exp("R10 unmapped low", 13'h0400, 32'h0);
    rd_exp("R10 unmapped high window", 13'h0FFC, 32'h0);
    rd_exp("R10 unmapped global gap", 13'h1010, 32'h0);
    rd_exp("R10 unmapped top", 13'h1FFC, 32'h0);
    rw("R10 write to gap", 1, 13'h1010, 32'hFFFF_FFFF);
    rw("R10 write to hole", 1, 13'h0800, 32'hFFFF_FFFF);
    chk("R10 no channel request", req_cnt, cnt0);
    rd_exp("R10 ctrl untouched", 13'h1000, 32'h1);
    rd_exp("R10 prog untouched", 13'h101C, 32'hA5A5_5A5A);

    // R11 back-pressure on the response
    bus(0, 13'h101C, 0, 0, 0, 0, 0, 3, rd, ex);
    chk("R11 held response data", rd, 32'hA5A5_5A5A);
    bus(0, 13'h0068, 0, 0, 0, 0, 0, 2, rd, ex);
    chk("R11 held channel response", rd, 32'h1111_3333);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule